// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block lives inside an SDRAM memory controller and keeps a four-bank device refreshed. An interval counter, sized from the clock frequency so that the average spacing of auto-refresh commands meets a budget of 4096 refreshes per 64 ms, adds one to a count of refreshes owed each time it expires. While refreshes are owed, the scheduler asks the command arbiter for a slot. One auto-refresh covers all four banks together, so it is requested only when every bank is idle. If a row is still open, a precharge-all is requested first.

The controller can also put the device into self refresh. The scheduler closes any open rows. It then issues an auto-refresh with clock enable driven low and holds clock enable low for as long as the request stays up. When the request drops, clock enable rises and one auto-refresh is issued before normal scheduling resumes. Up to eight owed refreshes can be deferred while the arbiter withholds its grant. At that limit the request is marked urgent.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, cke is 1, cmd_valid is 0, cmd_urgent is 0 and owed_count is 0.
- R2: owed_count rises by one every INTERVAL = CLK_MHZ*WINDOW_US/REFRESHES cycles, counted from the release of reset.
- R3: One cycle after owed_count becomes non-zero, with banks_idle high, cmd_valid is 1 with cmd_kind = 1 (auto-refresh).
- R4: A granted auto-refresh (cmd_valid and cmd_grant high in the same cycle) lowers owed_count by one at the next edge.
- R5: If banks_idle is low when a refresh is due, the first request has cmd_kind = 0 (precharge-all). Only after that grant is an auto-refresh requested.
- R6: cmd_valid with cmd_kind = 1 is never presented while banks_idle is low.
- R7: owed_count saturates at OWED_MAX (8). cmd_urgent is 1 exactly while owed_count equals OWED_MAX.
- R8: Raising self_ref_req from idle leads to a precharge-all if banks are busy, followed by an auto-refresh request during which cke is 0.
- R9: After the entry refresh is granted, cke stays 0, cmd_valid stays 0 and owed_count stays 0 for as long as self_ref_req is high.
- R10: When self_ref_req drops, cke returns to 1 at the next edge and one auto-refresh is requested. After its grant the scheduler is idle with owed_count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_ref_req | input | 1 | Request to enter and remain in self refresh |
| banks_idle | input | 1 | High when all four banks are precharged |
| cmd_grant | input | 1 | Arbiter accepts the presented command this cycle |
| cmd_valid | output | 1 | A command is being requested |
| cmd_kind | output | 1 | 0 = precharge-all, 1 = auto-refresh |
| cmd_urgent | output | 1 | Owed refreshes have reached the limit |
| cke | output | 1 | Clock-enable level for the device |
| owed_count | output | $clog2(OWED_MAX+1) (4) | Refreshes currently owed |

## Verification
The state register moves one edge after the condition that drives it. A request therefore appears one cycle after owed_count changes, and cke changes one edge after self_ref_req. owed_count steps on the edge that ends an interval or that follows a grant. cmd_valid follows banks_idle within the same cycle while a refresh is pending. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the release of reset for the interval check, and elsewhere it checks one falling edge after the edge that should cause each change.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_MHZ   = 100,
  parameter int WINDOW_US = 64000,
  parameter int REFRESHES = 4096,
  parameter int OWED_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic self_ref_req,
  input  logic banks_idle,
  input  logic cmd_grant,
  output logic cmd_valid,
  output logic cmd_kind,
  output logic cmd_urgent,
  output logic cke,
  output logic [$clog2(OWED_MAX+1)-1:0] owed_count
);
  localparam int INTERVAL = (CLK_MHZ * WINDOW_US) / REFRESHES;
  localparam int CW = $clog2(INTERVAL + 1);
  localparam int OW = $clog2(OWED_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_REF, S_SR_PRE, S_SR_ENT, S_SR_HOLD, S_EXIT_REF
  } state_t;

  state_t state, state_nx;
  logic [CW-1:0] cnt;
  logic hold_clk, tick, issue, ref_done, inc;

  assign hold_clk = (state == S_SR_HOLD) || (state == S_EXIT_REF);
  assign tick     = !hold_clk && (cnt == CW'(INTERVAL - 1));
  assign issue    = cmd_valid && cmd_grant;
  assign ref_done = issue && (state == S_REF);
  assign inc      = tick && (owed_count < OW'(OWED_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n || hold_clk || tick) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed_count <= '0;
    else if (state == S_SR_ENT && issue) owed_count <= '0;
    else owed_count <= owed_count + OW'(inc) - OW'(ref_done);
  end

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:
        if (self_ref_req) state_nx = banks_idle ? S_SR_ENT : S_SR_PRE;
        else if (owed_count != '0) state_nx = banks_idle ? S_REF : S_PRE;
      S_PRE:      if (issue) state_nx = S_REF;
      S_REF:      if (issue) state_nx = S_IDLE;
      S_SR_PRE:   if (issue) state_nx = S_SR_ENT;
      S_SR_ENT:   if (issue) state_nx = S_SR_HOLD;
      S_SR_HOLD:  if (!self_ref_req) state_nx = S_EXIT_REF;
      S_EXIT_REF: if (issue) state_nx = S_IDLE;
      default:    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else state <= state_nx;
  end

  always_comb begin
    case (state)
      S_PRE, S_SR_PRE:              cmd_valid = 1'b1;
      S_REF, S_SR_ENT, S_EXIT_REF:  cmd_valid = banks_idle;
      default:                      cmd_valid = 1'b0;
    endcase
  end

  assign cmd_kind   = (state == S_REF) || (state == S_SR_ENT) || (state == S_EXIT_REF);
  assign cke        = !((state == S_SR_ENT) || (state == S_SR_HOLD));
  assign cmd_urgent = (owed_count == OW'(OWED_MAX));

  p_ref_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind) |-> banks_idle);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    owed_count <= OW'(OWED_MAX));

  p_urgent_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_urgent && !ref_done && state != S_SR_ENT) |=> cmd_urgent);

  p_owed_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && !tick) |=> owed_count == $past(owed_count) - OW'(1));

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SR_HOLD) |-> (!cmd_valid && !cke && owed_count == '0));

  p_cke_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (state == S_EXIT_REF && cmd_kind));
endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  localparam int IV = 15;
  logic clk = 0, rst_n = 0, self_ref_req = 0, banks_idle = 1, cmd_grant = 0;
  logic cmd_valid, cmd_kind, cmd_urgent, cke;
  logic [3:0] owed_count;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sdram_refresh_sched #(.CLK_MHZ(1), .WINDOW_US(64000), .REFRESHES(4096), .OWED_MAX(8))
    u_sdram_refresh_sched (.clk(clk), .rst_n(rst_n), .self_ref_req(self_ref_req),
      .banks_idle(banks_idle), .cmd_grant(cmd_grant), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_urgent(cmd_urgent), .cke(cke), .owed_count(owed_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic grant_once();
    cmd_grant = 1;
    @(negedge clk);
    cmd_grant = 0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200 && !cmd_valid; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && owed_count != 0; i++) begin
      wait_valid();
      grant_once();
    end
    edges(1);
  endtask

  task automatic t_reset();
    chk("R1 cke", cke, 1); chk("R1 valid", cmd_valid, 0);
    chk("R1 urgent", cmd_urgent, 0); chk("R1 owed", owed_count, 0);
  endtask

  task automatic t_interval();
    edges(IV - 1); chk("R2 owed before interval", owed_count, 0);
    edges(1);      chk("R2 owed after interval", owed_count, 1);
    chk("R3 no request yet", cmd_valid, 0);
    edges(1);      chk("R3 valid", cmd_valid, 1); chk("R3 kind", cmd_kind, 1);
    grant_once();  chk("R4 owed decremented", owed_count, 0);
    chk("R4 request dropped", cmd_valid, 0);
  endtask

  task automatic t_busy();
    banks_idle = 0;
    wait_valid();  chk("R5 first is precharge", cmd_kind, 0);
    grant_once();  chk("R6 refresh withheld while busy", cmd_valid, 0);
    banks_idle = 1; #1;
    chk("R5 refresh after precharge", cmd_valid, 1); chk("R5 kind", cmd_kind, 1);
    @(negedge clk); grant_once();
    chk("R4 owed after busy refresh", owed_count, 0);
  endtask

  task automatic t_saturate();
    edges(9 * IV + 5);
    chk("R7 saturated", owed_count, 8); chk("R7 urgent", cmd_urgent, 1);
    wait_valid(); grant_once();
    chk("R7 one below limit", owed_count, 7); chk("R7 urgent cleared", cmd_urgent, 0);
    drain();
  endtask

  task automatic t_self_refresh();
    banks_idle = 0; self_ref_req = 1;
    edges(1);
    chk("R8 precharge first", cmd_valid, 1); chk("R8 kind", cmd_kind, 0); chk("R8 cke", cke, 1);
    grant_once();
    chk("R8 cke low on entry", cke, 0); chk("R6 entry waits idle", cmd_valid, 0);
    banks_idle = 1; #1;
    chk("R8 entry refresh", cmd_valid, 1); chk("R8 entry kind", cmd_kind, 1);
    @(negedge clk); grant_once();
    chk("R9 cke held", cke, 0); chk("R9 quiet", cmd_valid, 0);
    edges(4 * IV);
    chk("R9 cke still low", cke, 0); chk("R9 still quiet", cmd_valid, 0);
    chk("R9 no owed", owed_count, 0);
    self_ref_req = 0;
    edges(1);
    chk("R10 cke up", cke, 1); chk("R10 exit refresh", cmd_valid, 1); chk("R10 kind", cmd_kind, 1);
    grant_once();
    chk("R10 done", cmd_valid, 0); chk("R10 owed", owed_count, 0); chk("R10 cke", cke, 1);
  endtask

  initial begin
    fork
      begin
        edges(3); rst_n = 1; #1;
        t_reset();
        t_interval();
        t_busy();
        drain();
        t_saturate();
        t_self_refresh();
      end
      begin
        edges(20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule